// File: doc/BRIEF.md
# Eight-Port Programmable Parallel I/O Controller

This block is a byte-wide register-mapped controller for eight 8-bit parallel ports. A host reads and writes sixteen byte registers through a small synchronous interface. Each port can be switched between input and output by one bit of a direction register. A port set as input reports its live pins when read. A port set as output drives its held latch onto its output bus and reports that latch when read.

Alongside the ports, the block has a control register with two discrete output lines. One line is a display enable. The other is a run line that a host inverts to form an active-low reset for a companion processor. Four indices return a fixed four-character identification string. Only the low four address bits are decoded, so the window repeats across the wider address space. Only the low byte lane of the host data bus carries data.

Whenever the direction register is written, every port whose bit changed is re-driven. A port that became an output starts driving its latch, and a port that became an input drops to zero.

Top module: `pio8_ctrl`

## Requirements
- R1: After reset the direction register, the control register and all port latches are zero, every output bus and output-valid bit is zero, both control lines are low, and read data is zero.
- R2: Only the low four bits of the host address select a register, so any address whose low nibble matches reaches the same register.
- R3: Read data is registered and appears one clock after the read strobe. At indices 0 to 7 (port A to H), reading a port whose direction bit is 1 returns its latch, and reading a port whose direction bit is 0 returns its input pins.
- R4: Indices 8, 9, 10 and 11 read the identification bytes "P", "I", "O" and "8" in that order. Writes to these indices leave the readback unchanged.
- R5: The control register is reachable at index 12 and at its mirror index 14. The direction register is reachable at index 13 and at its mirror index 15. Both indices of a pair read and write the same storage.
- R6: Direction bit i = 1 makes port i an output. The output-valid bit of port i equals direction bit i, and the output bus of a port that is an input is zero.
- R7: A write to a port index always updates that port's latch. The port's output bus takes the new value on the next clock only if the port is an output at that time.
- R8: On a direction write, each port whose bit changed is re-driven on the next clock: with its latch if it became an output, or with zero if it became an input. Ports whose bit did not change keep their output.
- R9: Control bit 1 drives the display-enable line and control bit 2 drives the companion run line. Both follow a control write on the next clock.
- R10: With a host bus wider than one byte, a write whose low byte-enable bit is 0 changes no register. Data on the upper byte lanes is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | ADDR_W | Host address; low four bits select the register |
| host_wdata | input | HOST_W | Host write data; low byte lane used |
| host_be | input | HOST_W/DW | Byte enables; bit 0 qualifies writes |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | DW | Registered read data |
| port_in | input | NPORT*DW | Input pins, port A in the low byte |
| port_out | output | NPORT*DW | Output buses, port A in the low byte |
| port_oe | output | NPORT | Output-valid per port |
| disp_en | output | 1 | Display-enable line (control bit 1) |
| comp_run | output | 1 | Companion run line (control bit 2) |

## Verification
The bench builds the block with its defaults: a 16-bit host bus with two byte enables, an 8-bit address, and eight 8-bit ports. The wide bus makes it possible to write with only the upper byte enable set and to put junk on the upper data lane. The extra address bits above the decoded nibble let the bench reach registers through aliased addresses. With eight ports, the bench can toggle port A and port H in one direction write while watching that the unchanged port keeps its bus.

// File: rtl/pio8_pkg.sv
package pio8_pkg;

   localparam int IDX_W = 4;

   typedef enum logic [1:0] {
      SEL_PORT = 2'd0,
      SEL_SIG  = 2'd1,
      SEL_CTL  = 2'd2,
      SEL_DIR  = 2'd3
   } sel_e;

   localparam int CTL_DISP_BIT = 1;
   localparam int CTL_RUN_BIT  = 2;

   function automatic sel_e classify(input logic [IDX_W-1:0] idx);
      if (!idx[3])           return SEL_PORT;
      else if (!idx[2])      return SEL_SIG;
      else if (!idx[0])      return SEL_CTL;
      else                   return SEL_DIR;
   endfunction

endpackage

// File: rtl/pio8_port_slice.sv
module pio8_port_slice #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lat_we,
   input  logic [DW-1:0] wdata,
   input  logic          dir_now,
   input  logic          dir_we,
   input  logic          dir_new,
   output logic [DW-1:0] latch_q,
   output logic [DW-1:0] pout_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
      end else if (lat_we) begin
         latch_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pout_q <= '0;
      end else if (dir_we && (dir_new != dir_now)) begin
         pout_q <= dir_new ? latch_q : '0;
      end else if (lat_we && dir_now) begin
         pout_q <= wdata;
      end
   end

   // R8
   redrive_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_we && dir_new && !dir_now) |=> (pout_q == $past(latch_q)));

   // R6
   input_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_now |-> (pout_q == '0));

endmodule

// File: rtl/pio8_ctlregs.sv
module pio8_ctlregs
   import pio8_pkg::*;
#(
   parameter int DW    = 8,
   parameter int NPORT = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ok,
   input  logic             wr_raw,
   input  sel_e             sel,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    ctl_q,
   output logic [NPORT-1:0] dir_q,
   output logic             dir_we,
   output logic [NPORT-1:0] dir_new
);

   assign dir_we  = wr_ok && (sel == SEL_DIR);
   assign dir_new = wdata[NPORT-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         dir_q <= '0;
      end else if (wr_ok) begin
         if (sel == SEL_CTL) ctl_q <= wdata;
         if (sel == SEL_DIR) dir_q <= dir_new;
      end
   end

   // R10
   lane_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_raw && !wr_ok) |=> ($stable(ctl_q) && $stable(dir_q)));

endmodule

// File: rtl/pio8_rdmux.sv
module pio8_rdmux
   import pio8_pkg::*;
#(
   parameter int          DW        = 8,
   parameter int          NPORT     = 8,
   parameter logic [31:0] SIGNATURE = 32'h50494F38
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd,
   input  logic [IDX_W-1:0]    idx,
   input  sel_e                sel,
   input  logic [NPORT*DW-1:0] latch_flat,
   input  logic [NPORT*DW-1:0] pin_flat,
   input  logic [NPORT-1:0]    dir_q,
   input  logic [DW-1:0]       ctl_q,
   output logic [DW-1:0]       rdata_q
);

   localparam int PW = $clog2(NPORT);

   logic [PW-1:0] pi;
   logic [DW-1:0] port_val;
   logic [7:0]    sig_byte;
   logic [DW-1:0] nxt;

   assign pi       = idx[PW-1:0];
   assign port_val = dir_q[pi] ? latch_flat[pi*DW +: DW] : pin_flat[pi*DW +: DW];
   assign sig_byte = SIGNATURE[(3 - int'(idx[1:0]))*8 +: 8];

   always_comb begin
      unique case (sel)
         SEL_PORT: nxt = port_val;
         SEL_SIG:  nxt = DW'(sig_byte);
         SEL_CTL:  nxt = ctl_q;
         default:  nxt = DW'(dir_q);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata_q <= '0;
      else if (rd) rdata_q <= nxt;
   end

   // R4
   sig_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && sel == SEL_SIG) |=>
         (rdata_q == DW'(SIGNATURE[(3 - int'($past(idx[1:0])))*8 +: 8])));

endmodule

// File: rtl/pio8_ctrl.sv
module pio8_ctrl
   import pio8_pkg::*;
#(
   parameter int          DW        = 8,
   parameter int          NPORT     = 8,
   parameter int          ADDR_W    = 8,
   parameter int          HOST_W    = 16,
   parameter logic [31:0] SIGNATURE = 32'h50494F38
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      host_addr,
   input  logic [HOST_W-1:0]      host_wdata,
   input  logic [HOST_W/DW-1:0]   host_be,
   input  logic                   host_wr,
   input  logic                   host_rd,
   output logic [DW-1:0]          host_rdata,
   input  logic [NPORT*DW-1:0]    port_in,
   output logic [NPORT*DW-1:0]    port_out,
   output logic [NPORT-1:0]       port_oe,
   output logic                   disp_en,
   output logic                   comp_run
);

   localparam int LANES = HOST_W / DW;

   if (NPORT != 8) begin : g_bad_nport
      $error("pio8_ctrl: the index map needs exactly eight ports");
   end
   if (DW < 8) begin : g_bad_dw
      $error("pio8_ctrl: port width must hold a signature byte");
   end
   if ((HOST_W % DW) != 0) begin : g_bad_host
      $error("pio8_ctrl: host width must be a multiple of the port width");
   end
   if (ADDR_W < IDX_W) begin : g_bad_addr
      $error("pio8_ctrl: address narrower than the register index");
   end

   logic [IDX_W-1:0]    idx;
   sel_e                sel;
   logic                lane_ok;
   logic                wr_ok;
   logic [DW-1:0]       wbyte;
   logic [DW-1:0]       ctl_q;
   logic [NPORT-1:0]    dir_q;
   logic                dir_we;
   logic [NPORT-1:0]    dir_new;
   logic [NPORT*DW-1:0] latch_flat;

   assign idx   = host_addr[IDX_W-1:0];
   assign sel   = classify(idx);
   assign wbyte = host_wdata[DW-1:0];

   if (LANES > 1) begin : g_wide
      logic unused_hi;
      assign lane_ok   = host_be[0];
      assign unused_hi = ^{host_wdata[HOST_W-1:DW], host_be[LANES-1:1]};
   end else begin : g_narrow
      assign lane_ok = host_be[0];
   end

   if (ADDR_W > IDX_W) begin : g_alias
      logic unused_addr;
      assign unused_addr = ^host_addr[ADDR_W-1:IDX_W];
   end

   assign wr_ok = host_wr && lane_ok;

   pio8_ctlregs #(.DW(DW), .NPORT(NPORT)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ok   (wr_ok),
      .wr_raw  (host_wr),
      .sel     (sel),
      .wdata   (wbyte),
      .ctl_q   (ctl_q),
      .dir_q   (dir_q),
      .dir_we  (dir_we),
      .dir_new (dir_new)
   );

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic lat_we;
      assign lat_we = wr_ok && (sel == SEL_PORT) && (int'(idx[2:0]) == p);
      pio8_port_slice #(.DW(DW)) u_slice (
         .clk     (clk),
         .rst_n   (rst_n),
         .lat_we  (lat_we),
         .wdata   (wbyte),
         .dir_now (dir_q[p]),
         .dir_we  (dir_we),
         .dir_new (dir_new[p]),
         .latch_q (latch_flat[p*DW +: DW]),
         .pout_q  (port_out[p*DW +: DW])
      );
   end

   pio8_rdmux #(.DW(DW), .NPORT(NPORT), .SIGNATURE(SIGNATURE)) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd         (host_rd),
      .idx        (idx),
      .sel        (sel),
      .latch_flat (latch_flat),
      .pin_flat   (port_in),
      .dir_q      (dir_q),
      .ctl_q      (ctl_q),
      .rdata_q    (host_rdata)
   );

   assign port_oe  = dir_q;
   assign disp_en  = ctl_q[CTL_DISP_BIT];
   assign comp_run = ctl_q[CTL_RUN_BIT];

   // R9
   ctl_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && sel == SEL_CTL) |=>
         (disp_en == $past(wbyte[CTL_DISP_BIT]) && comp_run == $past(wbyte[CTL_RUN_BIT])));

endmodule

// File: tb/sim_pio8_ctrl.sv
module sim_pio8_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 8, NPORT = 8, ADDR_W = 8, HOST_W = 16;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [ADDR_W-1:0]    host_addr = '0;
   logic [HOST_W-1:0]    host_wdata = '0;
   logic [1:0]           host_be = '0;
   logic                 host_wr = 1'b0;
   logic                 host_rd = 1'b0;
   logic [DW-1:0]        host_rdata;
   logic [NPORT*DW-1:0]  port_in = '0;
   logic [NPORT*DW-1:0]  port_out;
   logic [NPORT-1:0]     port_oe;
   logic                 disp_en, comp_run;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   pio8_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_be(host_be), .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
      .port_in(port_in), .port_out(port_out), .port_oe(port_oe),
      .disp_en(disp_en), .comp_run(comp_run)
   );

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] addr, logic [7:0] data, logic [1:0] be = 2'b01);
      @(negedge clk);
      host_addr  = addr;
      host_wdata = {8'hA5, data};
      host_be    = be;
      host_wr    = 1'b1;
      @(negedge clk);
      host_wr    = 1'b0;
      host_be    = '0;
   endtask

   task automatic rd(logic [7:0] addr, logic [7:0] exp, string tag);
      @(negedge clk);
      host_addr = addr;
      host_rd   = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   function automatic logic [7:0] pbyte(logic [NPORT*DW-1:0] v, int p);
      return v[p*DW +: DW];
   endfunction

   // monitor: pops one expected byte per read strobe seen at an edge
   initial begin
      forever begin
         logic was_rd;
         @(posedge clk);
         was_rd = host_rd;
         #(CLK_PERIOD/4);
         if (was_rd && rst_n) begin
            if (exp_q.size() == 0) begin
               n_checks++; n_fail++;
               $display("FAIL scoreboard: read with no expected item, actual %0h expected none", host_rdata);
            end else begin
               logic [7:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(t, 64'(host_rdata), 64'(e));
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 port_out", 64'(port_out), 64'h0);
      check("R1 port_oe", 64'(port_oe), 64'h0);
      check("R1 ctl lines", 64'({disp_en, comp_run}), 64'h0);
      check("R1 rdata", 64'(host_rdata), 64'h0);
      rd(8'h0D, 8'h00, "R1 dir reads zero");
      rd(8'h0C, 8'h00, "R1 ctl reads zero");

      // R3 input port returns pins
      port_in[0 +: 8] = 8'h5A;
      rd(8'h00, 8'h5A, "R3 input pins A");
      // R7 latch write on input port: bus stays zero
      wr(8'h00, 8'h3C);
      check("R7 input port bus quiet", 64'(pbyte(port_out, 0)), 64'h0);
      rd(8'h00, 8'h5A, "R3 pins still read while input");

      // R8 direction set: A re-driven with latch
      wr(8'h0D, 8'h01);
      check("R6 oe follows dir", 64'(port_oe), 64'h01);
      check("R8 became output drives latch", 64'(pbyte(port_out, 0)), 64'h3C);
      rd(8'h00, 8'h3C, "R3 output port reads latch");
      rd(8'h0F, 8'h01, "R5 dir mirror read");

      // R7 write to output port
      wr(8'h00, 8'h77);
      check("R7 output port follows write", 64'(pbyte(port_out, 0)), 64'h77);

      // R8 clear through mirror: A drops to zero
      wr(8'h0F, 8'h00);
      check("R8 became input drives zero", 64'(pbyte(port_out, 0)), 64'h0);
      check("R6 oe cleared", 64'(port_oe), 64'h0);
      rd(8'h0D, 8'h00, "R5 dir written via mirror");

      // R4 signature
      rd(8'h08, 8'h50, "R4 sig byte 0");
      rd(8'h09, 8'h49, "R4 sig byte 1");
      rd(8'h0A, 8'h4F, "R4 sig byte 2");
      rd(8'h0B, 8'h38, "R4 sig byte 3");
      wr(8'h09, 8'hFF);
      rd(8'h09, 8'h49, "R4 sig write ignored");

      // R9 control via mirror
      wr(8'h0E, 8'h06);
      check("R9 both lines high", 64'({disp_en, comp_run}), 64'h3);
      rd(8'h0C, 8'h06, "R5 ctl mirror read");
      wr(8'h0C, 8'h02);
      check("R9 run low disp high", 64'({disp_en, comp_run}), 64'h2);

      // R10 upper lane only: ignored
      wr(8'h0D, 8'hFF, 2'b10);
      check("R10 oe unchanged", 64'(port_oe), 64'h0);
      rd(8'h0D, 8'h00, "R10 dir unchanged");
      wr(8'h0C, 8'h00, 2'b10);
      check("R10 ctl unchanged", 64'({disp_en, comp_run}), 64'h2);

      // R2 aliased addresses
      rd(8'h38, 8'h50, "R2 alias sig");
      wr(8'hF7, 8'h99);
      wr(8'h7D, 8'h80);
      check("R2 R8 port H driven via alias", 64'(pbyte(port_out, 7)), 64'h99);
      check("R2 oe via alias", 64'(port_oe), 64'h80);

      // R8 toggle A on, H unchanged keeps bus
      wr(8'h0D, 8'h81);
      check("R8 A re-driven", 64'(pbyte(port_out, 0)), 64'h77);
      check("R8 H kept", 64'(pbyte(port_out, 7)), 64'h99);
      port_in[8 +: 8] = 8'hC3;
      rd(8'h01, 8'hC3, "R3 port B pins");

      repeat (4) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_checks++; n_fail++;
         $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule